// File: doc/BRIEF.md
# Frequency sweep measurement sequencer

This block runs a stepped-frequency reflection measurement. Once started by the host, it tunes the test oscillator to each frequency of a sweep in turn. At every point it waits a settling time, then reads a two-channel ADC repeatedly. One channel carries the in-phase detector voltage and the other carries the quadrature detector voltage.

The readings at a point are summed in signed accumulators. The sums are divided by the averaging count with an arithmetic shift. The averaged pair leaves the block with the frequency it was taken at, over a valid/ready handshake. The sweep waits for as long as the consumer holds ready low.

The sweep settings are taken from the configuration inputs in the cycle the sweep is started:

- first frequency
- last frequency
- increment
- settling time in cycles
- averaging exponent

Out-of-range values are clamped to legal limits when they are captured. The ADC is reached through a one-cycle request pulse, answered some cycles later by a valid strobe carrying the sample. Requests are spaced so the converter's conversion rate is never exceeded. An abort input stops the block at any moment.

Top module: `sweep_seq`

## Requirements
- R1: After reset, and until `start` is seen, `busy`, `done`, `osc_load`, `adc_req` and `res_valid` are all low.
- R2: When `start` is seen, the settings are clamped before they are captured:
  - Both frequency limits are clamped into [F_MIN, F_MAX].
  - A zero step becomes 1.
  - A settling time below MIN_HOLD becomes MIN_HOLD.
  - An averaging exponent above AVG_LOG2_MAX becomes AVG_LOG2_MAX.
- R3: Each point begins with a one-cycle `osc_load` pulse carrying the point's frequency.
- R3 (continued): The points are first, first+step, first+2·step and so on. Each point is at most the last frequency, except that the first point is always measured, even when the last frequency lies below the first.
- R4: The first ADC request of a point comes at least the clamped settling time in cycles after that point's `osc_load` pulse.
- R5: Each reading is two requests: `adc_ch`=0 (in-phase) followed by `adc_ch`=1 (quadrature). A point takes 2^k readings, where k is the clamped exponent.
- R6: Two `adc_req` pulses are always at least PACE_CYC cycles apart.
- R7: `res_i` and `res_q` equal the signed sum of the point's in-phase and quadrature samples, arithmetically shifted right by k. `res_freq` is the point's frequency.
- R8: While `res_valid` is high and `res_ready` is low:
  - the result outputs hold steady;
  - no ADC request is issued;
  - the sweep does not advance.
- R9: When the next point would pass the last frequency, `busy` falls and `done` rises. `done` then stays high until the next `start` or `abort`.
- R10: One cycle after `abort` is high, `busy`, `done`, `res_valid` and `adc_req` are all low. ADC strobes that arrive afterwards while the block is idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_f_start | input | FREQ_W | First sweep frequency, Hz |
| cfg_f_stop | input | FREQ_W | Last sweep frequency, Hz |
| cfg_f_step | input | FREQ_W | Frequency increment, Hz |
| cfg_hold | input | HOLD_W | Settling time per point, cycles |
| cfg_avg_log2 | input | AVG_SEL_W | Averaging exponent k (2^k readings) |
| start | input | 1 | Begin a sweep (taken only when idle) |
| abort | input | 1 | Return to idle at once |
| osc_freq | output | FREQ_W | Oscillator frequency word |
| osc_load | output | 1 | One-cycle pulse: load `osc_freq` |
| adc_req | output | 1 | One-cycle conversion request |
| adc_ch | output | 1 | Channel of the request: 0 in-phase, 1 quadrature |
| adc_valid | input | 1 | Conversion result strobe |
| adc_data | input | SMP_W | Signed conversion result |
| res_valid | output | 1 | Averaged result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_freq | output | FREQ_W | Frequency of the result |
| res_i | output | ACC_W | Averaged in-phase value, signed |
| res_q | output | ACC_W | Averaged quadrature value, signed |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep finished normally |

## Verification
Two functions of the block can fall on the same clock edge.

The first collision is an `abort` arriving while a result is stalled with `res_ready` low. To provoke it, the bench withholds ready on a finished point and raises `abort` during the stall. It then judges that `res_valid` drops in the next cycle, that no later ADC strobe revives the sweep, and that `done` stays low.

The second collision is the result stall overlapping the conversion pacer, whose countdown keeps running meanwhile. A stalled vector holds ready low for several cycles. The bench checks that the result stays steady and that no request leaks out. It also checks that the first request after the stall still respects the request spacing.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SET,
      S_HOLD,
      S_SAMPLE,
      S_ACCUM,
      S_EMIT,
      S_NEXT
   } seq_state_t;

endpackage

// File: rtl/sweep_cfg_clamp.sv
module sweep_cfg_clamp #(
   parameter int FREQ_W       = 32,
   parameter int HOLD_W       = 32,
   parameter int AVG_SEL_W    = 4,
   parameter int AVG_LOG2_MAX = 8,
   parameter int F_MIN        = 1000,
   parameter int F_MAX        = 50_000_000,
   parameter int MIN_HOLD     = 30000
) (
   input  logic [FREQ_W-1:0]    raw_start,
   input  logic [FREQ_W-1:0]    raw_stop,
   input  logic [FREQ_W-1:0]    raw_step,
   input  logic [HOLD_W-1:0]    raw_hold,
   input  logic [AVG_SEL_W-1:0] raw_k,
   output logic [FREQ_W-1:0]    lim_start,
   output logic [FREQ_W-1:0]    lim_stop,
   output logic [FREQ_W-1:0]    lim_step,
   output logic [HOLD_W-1:0]    lim_hold,
   output logic [AVG_SEL_W-1:0] lim_k
);
   localparam logic [FREQ_W-1:0]    FLO  = FREQ_W'(F_MIN);
   localparam logic [FREQ_W-1:0]    FHI  = FREQ_W'(F_MAX);
   localparam logic [HOLD_W-1:0]    HLO  = HOLD_W'(MIN_HOLD);
   localparam logic [AVG_SEL_W-1:0] KMAX = AVG_SEL_W'(AVG_LOG2_MAX);

   function automatic logic [FREQ_W-1:0] fit_freq(input logic [FREQ_W-1:0] f);
      if (f < FLO) return FLO;
      if (f > FHI) return FHI;
      return f;
   endfunction

   always_comb begin
      lim_start = fit_freq(raw_start);
      lim_stop  = fit_freq(raw_stop);
      lim_step  = (raw_step == '0) ? FREQ_W'(1) : raw_step;
      lim_hold  = (raw_hold < HLO) ? HLO : raw_hold;
      lim_k     = (raw_k > KMAX) ? KMAX : raw_k;
   end

   always_comb begin
      assert (lim_start >= FLO && lim_start <= FHI && lim_stop >= FLO && lim_stop <= FHI)
         else $error("p_freq_window_r2");
      assert (lim_step != '0 && lim_hold >= HLO && lim_k <= KMAX)
         else $error("p_other_limits_r2");
   end
endmodule

// File: rtl/sweep_pacer.sv
module sweep_pacer #(
   parameter int PACE_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic req_out,
   output logic ok
);
   localparam int GAP_W = $clog2(PACE_CYC + 1) + 1;

   generate
      if (PACE_CYC <= 1) begin : g_free
         assign ok = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(PACE_CYC);
         logic [CW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          left <= '0;
            else if (fire)       left <= CW'(PACE_CYC - 1);
            else if (left != '0) left <= left - 1'b1;
         end
         assign ok = (left == '0);
      end
   endgenerate

   // spacing checker on the registered request output
   logic [GAP_W-1:0] gap;
   logic             seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (req_out) begin
         gap  <= '0;
         seen <= 1'b1;
      end else if (gap < GAP_W'(PACE_CYC)) begin
         gap <= gap + 1'b1;
      end
   end

   p_req_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_out && seen) |-> (gap >= GAP_W'(PACE_CYC - 1)));
endmodule

// File: rtl/sweep_iq_accum.sv
module sweep_iq_accum #(
   parameter int SMP_W        = 12,
   parameter int ACC_W        = 32,
   parameter int AVG_SEL_W    = 4,
   parameter int AVG_LOG2_MAX = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    add,
   input  logic signed [SMP_W-1:0] smp_i,
   input  logic signed [SMP_W-1:0] smp_q,
   input  logic [AVG_SEL_W-1:0]    shift,
   output logic                    last,
   output logic signed [ACC_W-1:0] avg_i,
   output logic signed [ACC_W-1:0] avg_q
);
   localparam int CNT_W = AVG_LOG2_MAX + 2;

   logic signed [ACC_W-1:0] sum [2];
   logic [CNT_W-1:0]        cnt;
   logic [CNT_W-1:0]        target;

   assign target = CNT_W'(1) << shift;
   assign last   = (cnt == target - 1'b1);

   generate
      for (genvar c = 0; c < 2; c++) begin : g_lane
         logic signed [SMP_W-1:0] s;
         assign s = (c == 0) ? smp_i : smp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sum[c] <= '0;
            else if (clr) sum[c] <= '0;
            else if (add) sum[c] <= sum[c] + ACC_W'(s);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (add) cnt <= cnt + 1'b1;
   end

   assign avg_i = sum[0] >>> shift;
   assign avg_q = sum[1] >>> shift;

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      add |-> (cnt < target));
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
   import sweep_pkg::*;
#(
   parameter int FREQ_W       = 32,
   parameter int HOLD_W       = 32,
   parameter int SMP_W        = 12,
   parameter int ACC_W        = 32,
   parameter int AVG_SEL_W    = 4,
   parameter int AVG_LOG2_MAX = 8,
   parameter int F_MIN        = 1000,
   parameter int F_MAX        = 50_000_000,
   parameter int MIN_HOLD     = 30000,
   parameter int PACE_CYC     = 200
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [FREQ_W-1:0]       cfg_f_start,
   input  logic [FREQ_W-1:0]       cfg_f_stop,
   input  logic [FREQ_W-1:0]       cfg_f_step,
   input  logic [HOLD_W-1:0]       cfg_hold,
   input  logic [AVG_SEL_W-1:0]    cfg_avg_log2,
   input  logic                    start,
   input  logic                    abort,
   output logic [FREQ_W-1:0]       osc_freq,
   output logic                    osc_load,
   output logic                    adc_req,
   output logic                    adc_ch,
   input  logic                    adc_valid,
   input  logic signed [SMP_W-1:0] adc_data,
   output logic                    res_valid,
   input  logic                    res_ready,
   output logic [FREQ_W-1:0]       res_freq,
   output logic signed [ACC_W-1:0] res_i,
   output logic signed [ACC_W-1:0] res_q,
   output logic                    busy,
   output logic                    done
);
   generate
      if (F_MIN < 1 || F_MIN > F_MAX) begin : g_bad_range
         $error("sweep_seq: frequency window is empty");
      end
      if (MIN_HOLD < 1) begin : g_bad_hold
         $error("sweep_seq: MIN_HOLD must be at least 1");
      end
      if (ACC_W < SMP_W + AVG_LOG2_MAX + 1) begin : g_bad_acc
         $error("sweep_seq: accumulator too narrow");
      end
      if (AVG_LOG2_MAX >= (1 << AVG_SEL_W)) begin : g_bad_sel
         $error("sweep_seq: averaging select too narrow");
      end
   endgenerate

   seq_state_t              state;
   logic [FREQ_W-1:0]       cur_freq, stop_r, step_r;
   logic [HOLD_W-1:0]       hold_r, hold_cnt;
   logic [AVG_SEL_W-1:0]    k_r;
   logic                    pend, ch;
   logic signed [SMP_W-1:0] smp_i, smp_q;
   logic [FREQ_W:0]         nxt;

   logic [FREQ_W-1:0]    c_start, c_stop, c_step;
   logic [HOLD_W-1:0]    c_hold;
   logic [AVG_SEL_W-1:0] c_k;
   logic                 pace_ok, fire, acc_last;

   sweep_cfg_clamp #(
      .FREQ_W(FREQ_W), .HOLD_W(HOLD_W), .AVG_SEL_W(AVG_SEL_W),
      .AVG_LOG2_MAX(AVG_LOG2_MAX), .F_MIN(F_MIN), .F_MAX(F_MAX),
      .MIN_HOLD(MIN_HOLD)
   ) u_clamp (
      .raw_start(cfg_f_start), .raw_stop(cfg_f_stop), .raw_step(cfg_f_step),
      .raw_hold(cfg_hold), .raw_k(cfg_avg_log2),
      .lim_start(c_start), .lim_stop(c_stop), .lim_step(c_step),
      .lim_hold(c_hold), .lim_k(c_k)
   );

   assign fire = (state == S_SAMPLE) && !pend && pace_ok && !abort;

   sweep_pacer #(.PACE_CYC(PACE_CYC)) u_pacer (
      .clk(clk), .rst_n(rst_n), .fire(fire), .req_out(adc_req), .ok(pace_ok)
   );

   sweep_iq_accum #(
      .SMP_W(SMP_W), .ACC_W(ACC_W), .AVG_SEL_W(AVG_SEL_W),
      .AVG_LOG2_MAX(AVG_LOG2_MAX)
   ) u_acc (
      .clk(clk), .rst_n(rst_n),
      .clr(state == S_SET), .add(state == S_ACCUM && !abort),
      .smp_i(smp_i), .smp_q(smp_q), .shift(k_r),
      .last(acc_last), .avg_i(res_i), .avg_q(res_q)
   );

   assign nxt = {1'b0, cur_freq} + {1'b0, step_r};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cur_freq  <= '0;
         stop_r    <= '0;
         step_r    <= '0;
         hold_r    <= '0;
         hold_cnt  <= '0;
         k_r       <= '0;
         pend      <= 1'b0;
         ch        <= 1'b0;
         smp_i     <= '0;
         smp_q     <= '0;
         osc_load  <= 1'b0;
         adc_req   <= 1'b0;
         res_valid <= 1'b0;
         done      <= 1'b0;
      end else begin
         osc_load <= 1'b0;
         adc_req  <= 1'b0;
         if (abort) begin
            state     <= S_IDLE;
            pend      <= 1'b0;
            ch        <= 1'b0;
            res_valid <= 1'b0;
            done      <= 1'b0;
         end else begin
            unique case (state)
               S_IDLE: if (start) begin
                  cur_freq <= c_start;
                  stop_r   <= c_stop;
                  step_r   <= c_step;
                  hold_r   <= c_hold;
                  k_r      <= c_k;
                  done     <= 1'b0;
                  state    <= S_SET;
               end
               S_SET: begin
                  osc_load <= 1'b1;
                  hold_cnt <= hold_r - 1'b1;
                  ch       <= 1'b0;
                  pend     <= 1'b0;
                  state    <= S_HOLD;
               end
               S_HOLD: begin
                  if (hold_cnt == '0) state <= S_SAMPLE;
                  else                hold_cnt <= hold_cnt - 1'b1;
               end
               S_SAMPLE: begin
                  if (pend && adc_valid) begin
                     pend <= 1'b0;
                     if (!ch) begin
                        smp_i <= adc_data;
                        ch    <= 1'b1;
                     end else begin
                        smp_q <= adc_data;
                        ch    <= 1'b0;
                        state <= S_ACCUM;
                     end
                  end else if (fire) begin
                     adc_req <= 1'b1;
                     pend    <= 1'b1;
                  end
               end
               S_ACCUM: begin
                  res_valid <= acc_last;
                  state     <= acc_last ? S_EMIT : S_SAMPLE;
               end
               S_EMIT: if (res_ready) begin
                  res_valid <= 1'b0;
                  state     <= S_NEXT;
               end
               S_NEXT: begin
                  if (nxt > {1'b0, stop_r}) begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     cur_freq <= nxt[FREQ_W-1:0];
                     state    <= S_SET;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   assign osc_freq = cur_freq;
   assign res_freq = cur_freq;
   assign adc_ch   = ch;
   assign busy     = (state != S_IDLE);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!adc_req && !res_valid && !osc_load));
   p_osc_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      osc_load |-> (osc_freq >= FREQ_W'(F_MIN) && osc_freq <= FREQ_W'(F_MAX)));
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready && !abort) |=>
         (res_valid && $stable(res_freq) && $stable(res_i) && $stable(res_q)));
   p_stall_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !adc_req);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !done && !res_valid && !adc_req));
endmodule

// File: tb/sim_sweep_seq.sv
module sim_sweep_seq;
   localparam int CLK_NS   = 10;
   localparam int HOLD_MIN = 16;
   localparam int PACE     = 6;
   localparam int LAT      = 3;
   localparam int NVEC     = 5;

   typedef struct packed {
      logic [31:0] f_start, f_stop, f_step, hold;
      logic [3:0]  k;
      logic        stall;
      logic [31:0] e_first, e_step, e_hold;
      logic [7:0]  e_pts;
      logic [3:0]  e_k;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{32'd1000, 32'd1030, 32'd10, 32'd20, 4'd0, 1'b0, 32'd1000, 32'd10, 32'd20, 8'd4, 4'd0},
      '{32'd500, 32'd1003, 32'd0, 32'd3, 4'd2, 1'b0, 32'd1000, 32'd1, 32'd16, 8'd4, 4'd2},
      '{32'd49_999_990, 32'd60_000_000, 32'd7, 32'd16, 4'd1, 1'b0,
        32'd49_999_990, 32'd7, 32'd16, 8'd2, 4'd1},
      '{32'd2000, 32'd1500, 32'd100, 32'd30, 4'd12, 1'b0, 32'd2000, 32'd100, 32'd30, 8'd1, 4'd8},
      '{32'd5000, 32'd5300, 32'd100, 32'd17, 4'd3, 1'b1, 32'd5000, 32'd100, 32'd17, 8'd4, 4'd3}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] cfg_f_start = '0, cfg_f_stop = '0, cfg_f_step = '0, cfg_hold = '0;
   logic [3:0]  cfg_avg_log2 = '0;
   logic start = 1'b0, abort = 1'b0, res_ready = 1'b1;
   logic adc_valid = 1'b0;
   logic signed [11:0] adc_data = '0;
   logic [31:0] osc_freq, res_freq;
   logic osc_load, adc_req, adc_ch, res_valid, busy, done;
   logic signed [31:0] res_i, res_q;

   sweep_seq #(.MIN_HOLD(HOLD_MIN), .PACE_CYC(PACE)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_f_start(cfg_f_start), .cfg_f_stop(cfg_f_stop),
      .cfg_f_step(cfg_f_step), .cfg_hold(cfg_hold), .cfg_avg_log2(cfg_avg_log2),
      .start(start), .abort(abort), .osc_freq(osc_freq), .osc_load(osc_load),
      .adc_req(adc_req), .adc_ch(adc_ch), .adc_valid(adc_valid), .adc_data(adc_data),
      .res_valid(res_valid), .res_ready(res_ready), .res_freq(res_freq),
      .res_i(res_i), .res_q(res_q), .busy(busy), .done(done)
   );

   always #(CLK_NS/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   int cyc = 0, load_cyc = 0, last_req = 0, nreq_pt = 0, nreq_all = 0, nload_all = 0;
   int sum_i = 0, sum_q = 0, seed = 1, exp_hold = 16, resp_cnt = 0;
   bit seen_req = 0, first_pt = 0, exp_ch = 0, resp_ch = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // ADC model and request monitor
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         adc_valid = 1'b0;
         if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
               logic [11:0] raw;
               raw       = 12'(seed * 37 + 11);
               seed++;
               adc_data  = $signed(raw);
               adc_valid = 1'b1;
               if (resp_ch) sum_q += int'(adc_data);
               else         sum_i += int'(adc_data);
            end
         end
         if (osc_load) begin
            load_cyc = cyc; nreq_pt = 0; sum_i = 0; sum_q = 0;
            exp_ch = 0; first_pt = 1; nload_all++;
         end
         if (adc_req) begin
            nreq_all++;
            if (first_pt && (cyc - load_cyc) < exp_hold)
               chk(0, "R4 settle gap", cyc - load_cyc, exp_hold);
            if (seen_req && (cyc - last_req) < PACE)
               chk(0, "R6 request spacing", cyc - last_req, PACE);
            if (adc_ch != exp_ch) chk(0, "R5 channel order", adc_ch, exp_ch);
            if (res_valid) chk(0, "R8 request during stall", 1, 0);
            first_pt = 0; seen_req = 1; last_req = cyc;
            exp_ch = ~exp_ch; nreq_pt++;
            resp_ch = adc_ch; resp_cnt = LAT;
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      chk(0, "watchdog expired", cyc, 190000);
      finish_run();
   end

   task automatic load_cfg(input vec_t v);
      cfg_f_start = v.f_start; cfg_f_stop = v.f_stop; cfg_f_step = v.f_step;
      cfg_hold = v.hold; cfg_avg_log2 = v.k;
      exp_hold = int'(v.e_hold);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_abort();
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
   endtask

   initial begin
      int rq0;
      int ld0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !res_valid && !adc_req && !osc_load, "R1 reset outputs",
          {busy, done, res_valid, adc_req}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(!busy && nreq_all == 0 && nload_all == 0, "R1 idle without start",
          nreq_all + nload_all, 0);

      for (int vi = 0; vi < NVEC; vi++) begin
         vec_t v;
         int   pts;
         logic [31:0] ef;
         v = VECS[vi];
         load_cfg(v);
         res_ready = !v.stall;
         pulse_start();
         chk(busy && !done, "R9 done cleared on start", done, 0);
         pts = 0;
         ef  = v.e_first;
         while (!done) begin
            @(negedge clk);
            if (res_valid) begin
               int ei, eq;
               ei = sum_i >>> v.e_k;
               eq = sum_q >>> v.e_k;
               chk(res_freq == ef, "R3 point frequency", res_freq, ef);
               chk(res_i == ei, "R7 in-phase average", res_i, ei);
               chk(res_q == eq, "R7 quadrature average", res_q, eq);
               chk(nreq_pt == (2 << v.e_k), "R5 requests per point", nreq_pt, 2 << v.e_k);
               if (v.stall) begin
                  for (int s = 0; s < 8; s++) begin
                     @(negedge clk);
                     chk(res_valid && res_freq == ef && res_i == ei && res_q == eq,
                         "R8 stalled result steady", res_i, ei);
                  end
                  res_ready = 1'b1;
               end
               @(negedge clk);
               res_ready = !v.stall;
               pts++;
               ef = ef + v.e_step;
            end
         end
         chk(pts == int'(v.e_pts), "R3 point count", pts, v.e_pts);
         chk(!busy && done, "R9 end of sweep", busy, 0);
         res_ready = 1'b1;
         repeat (4) @(negedge clk);
      end

      // R10 abort during settling/sampling, stale strobes ignored
      load_cfg(VECS[0]);
      pulse_start();
      while (!adc_req) @(negedge clk);
      pulse_abort();
      chk(!busy && !done && !res_valid && !adc_req, "R10 abort while sampling", busy, 0);
      rq0 = nreq_all; ld0 = nload_all;
      repeat (30) @(negedge clk);
      chk(!busy && nreq_all == rq0 && nload_all == ld0, "R10 stale strobe ignored",
          nreq_all - rq0, 0);

      // R10 abort colliding with a stalled result
      res_ready = 1'b0;
      pulse_start();
      while (!res_valid) @(negedge clk);
      repeat (3) @(negedge clk);
      pulse_abort();
      chk(!res_valid && !busy && !done, "R10 abort clears stalled result", res_valid, 0);
      res_ready = 1'b1;
      repeat (20) @(negedge clk);
      chk(!busy && !done && !res_valid, "R10 stays idle after abort", busy, 0);

      finish_run();
   end
endmodule